// File: doc/BRIEF.md
# Radix Translation Root Locator

This block finds where a radix translation tree begins, before any page-directory level is walked. A request carries a 64-bit control word that points at the partition table, an effective partition number and an effective process number. The block reads one doubleword of the partition entry to learn where the process table lives and how large it is. It then reads one doubleword of the process entry, which holds the root directory base, the root directory size and the tree size. Each table has its own bounds check and its own size code.

Every field position below uses big-endian bit numbering: bit 0 is the most significant bit of a 64-bit word, so field bits a..b sit at vector bits [63-a:63-b]. Memory is reached through a single read port. A read request lasts one cycle, and its response may arrive any number of cycles later. Each request ends with exactly one single-cycle `done` pulse or exactly one single-cycle `fault` pulse.

The state machine has ten states. IDLE goes to PART_CHK on `start`. PART_CHK goes to FAULT when the partition index is out of range, and to PART_RD otherwise. PART_RD goes to PART_WT. PART_WT waits for the response and then goes to PROC_CHK. PROC_CHK goes to FAULT when the process size code is too large or the process index is out of range, and to PROC_RD otherwise. PROC_RD goes to PROC_WT. PROC_WT waits for the response and then goes to ROOT_CHK. ROOT_CHK goes to FAULT when the root size code is too small, and to DONE otherwise. DONE and FAULT each return to IDLE after one cycle.

Top module: `radix_root_locator`

## Requirements
- R1: After reset the block is idle, with `done`, `fault` and `mem_req_valid` low.
- R2: The partition entry read uses this address: control bits 4..51 shifted left by 12, plus the partition index times 16, plus 8.
- R3: The partition table holds 2^(code+12) bytes, where the code is control bits 59..63. If the partition index times 16 is at least that size, the block raises `fault` and issues no read.
- R4: In the partition doubleword, bits 4..51 give the base field and bits 59..63 give the process size code. The process table base is the base field with its low (code) bits cleared, shifted left by 12. The process entry read uses this address: that base plus the process index times 16.
- R5: A process size code above 24 raises `fault` after exactly one read.
- R6: If the process index times 16 is at least 2^(code+12), the block raises `fault` after exactly one read.
- R7: On `done`, the outputs come from the process doubleword. `root_base` is bits 4..55 shifted left by 8. `root_idx_bits` is bits 59..63. `tree_bits` is {bits 1..2, bits 56..58} + 31.
- R8: A root size code (bits 59..63) below 5 raises `fault` after two reads.
- R9: At most one read is outstanding at a time, and each request pulse lasts one cycle. The block waits for a response of any latency. A response that arrives while no read is outstanding is ignored.
- R10: `done` and `fault` are never high together, and each lasts one cycle. A `start` that arrives while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a lookup (sampled only when idle) |
| ptcr | input | 64 | Partition table pointer and size code |
| lpid | input | LPID_W | Effective partition index |
| pid | input | PID_W | Effective process index |
| mem_req_valid | output | 1 | Read request, one cycle |
| mem_req_addr | output | 64 | Byte address of the requested doubleword |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Root found, one-cycle pulse |
| fault | output | 1 | Lookup failed, one-cycle pulse |
| root_base | output | 64 | Root directory byte address |
| root_idx_bits | output | 5 | Root directory index width |
| tree_bits | output | 6 | Effective address width covered by the tree |

## Verification
Some properties are checked on every cycle. A read request never lasts two cycles. `done` and `fault` are single pulses and never coincide. Partition reads always fall on byte offset 8 of a 16-byte entry, and process reads always on offset 0. A busy `start` cannot disturb the captured inputs. A completed lookup always reports a root width of at least 5 and a tree width of at least 31. Other behaviours need the bench's scenarios. These are the exact addresses issued, the base alignment, the table-size bounds and which fault path is taken, the number of reads before a fault, tolerance of response latency, and stray responses arriving while idle.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    localparam int DW          = 64;
    localparam int CODE_W      = 5;
    localparam int PAGE_SHIFT  = 12;
    localparam int ROOT_SHIFT  = 8;
    localparam int ENTRY_SHIFT = 4;
    localparam int PTR_FW      = 48;
    localparam int ROOT_FW     = 52;
    localparam logic [CODE_W-1:0] MAX_PROC_CODE = 5'd24;
    localparam logic [CODE_W-1:0] MIN_ROOT_CODE = 5'd5;
    localparam logic [5:0]        TREE_BIAS     = 6'd31;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PART_CHK,
        S_PART_RD,
        S_PART_WT,
        S_PROC_CHK,
        S_PROC_RD,
        S_PROC_WT,
        S_ROOT_CHK,
        S_DONE,
        S_FAULT
    } state_t;
endpackage

// File: rtl/rrf_table_ptr.sv
module rrf_table_ptr
    import rrf_pkg::*;
#(
    parameter int          IDX_W     = 12,
    parameter bit          ALIGN     = 1'b0,
    parameter logic [63:0] ENTRY_OFF = 64'd0
) (
    input  logic [DW-1:0]     dword,
    input  logic [IDX_W-1:0]  idx,
    output logic [DW-1:0]     entry_addr,
    output logic [CODE_W-1:0] size_code,
    output logic              out_of_range
);
    logic [PTR_FW-1:0] field;
    logic [PTR_FW-1:0] base_f;
    logic [DW-1:0]     base;
    logic [DW-1:0]     off;
    logic [5:0]        lim;

    // field bits 4..51 and 59..63, bit 0 being the MSB
    assign field     = dword[59:12];
    assign size_code = dword[4:0];

    generate
        if (ALIGN) begin : g_align
            assign base_f = field & ~((PTR_FW'(1) << size_code) - PTR_FW'(1));
        end else begin : g_raw
            assign base_f = field;
        end
    endgenerate

    assign base         = {4'b0, base_f, 12'b0};
    assign off          = DW'({idx, 4'b0});
    assign entry_addr   = base + off + ENTRY_OFF;
    assign lim          = {1'b0, size_code} + 6'(PAGE_SHIFT);
    assign out_of_range = (off >> lim) != '0;
endmodule

// File: rtl/rrf_root_decode.sv
module rrf_root_decode
    import rrf_pkg::*;
(
    input  logic [DW-1:0]     dword,
    output logic [DW-1:0]     root_base,
    output logic [CODE_W-1:0] idx_bits,
    output logic [5:0]        tree_bits,
    output logic              size_bad
);
    logic [1:0]         tsz_hi;
    logic [2:0]         tsz_lo;
    logic [ROOT_FW-1:0] rfield;

    assign tsz_hi    = dword[62:61];
    assign tsz_lo    = dword[7:5];
    assign rfield    = dword[59:8];
    assign idx_bits  = dword[4:0];
    assign root_base = {4'b0, rfield, 8'b0};
    assign tree_bits = {1'b0, tsz_hi, tsz_lo} + TREE_BIAS;
    assign size_bad  = idx_bits < MIN_ROOT_CODE;
endmodule

// File: rtl/rrf_fsm.sv
module rrf_fsm
    import rrf_pkg::*;
#(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DW-1:0]     ptcr_in,
    input  logic [LPID_W-1:0] lpid_in,
    input  logic [PID_W-1:0]  pid_in,
    input  logic              rsp_valid,
    input  logic [DW-1:0]     rsp_data,
    input  logic              part_oor,
    input  logic [CODE_W-1:0] proc_code,
    input  logic              proc_oor,
    input  logic              root_bad,
    input  logic [DW-1:0]     part_addr,
    input  logic [DW-1:0]     proc_addr,
    output logic [DW-1:0]     ptcr_q,
    output logic [LPID_W-1:0] lpid_q,
    output logic [PID_W-1:0]  pid_q,
    output logic [DW-1:0]     pate_q,
    output logic [DW-1:0]     prte_q,
    output logic              req_valid,
    output logic [DW-1:0]     req_addr,
    output logic              done,
    output logic              fault
);
    state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     if (start) state_nx = S_PART_CHK;
            S_PART_CHK: state_nx = part_oor ? S_FAULT : S_PART_RD;
            S_PART_RD:  state_nx = S_PART_WT;
            S_PART_WT:  if (rsp_valid) state_nx = S_PROC_CHK;
            S_PROC_CHK: state_nx = ((proc_code > MAX_PROC_CODE) || proc_oor) ? S_FAULT : S_PROC_RD;
            S_PROC_RD:  state_nx = S_PROC_WT;
            S_PROC_WT:  if (rsp_valid) state_nx = S_ROOT_CHK;
            S_ROOT_CHK: state_nx = root_bad ? S_FAULT : S_DONE;
            S_DONE:     state_nx = S_IDLE;
            S_FAULT:    state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptcr_q <= '0;
            lpid_q <= '0;
            pid_q  <= '0;
            pate_q <= '0;
            prte_q <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                ptcr_q <= ptcr_in;
                lpid_q <= lpid_in;
                pid_q  <= pid_in;
            end
            if (state == S_PART_WT && rsp_valid) pate_q <= rsp_data;
            if (state == S_PROC_WT && rsp_valid) prte_q <= rsp_data;
        end
    end

    always_comb begin
        req_valid = 1'b0;
        req_addr  = '0;
        done      = 1'b0;
        fault     = 1'b0;
        unique case (state)
            S_PART_RD: begin
                req_valid = 1'b1;
                req_addr  = part_addr;
            end
            S_PROC_RD: begin
                req_valid = 1'b1;
                req_addr  = proc_addr;
            end
            S_DONE:  done  = 1'b1;
            S_FAULT: fault = 1'b1;
            default: ;
        endcase
    end

    assert_req_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);
    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |=> $stable(lpid_q) && $stable(pid_q) && $stable(ptcr_q));
    assert_part_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PART_RD) |-> (req_addr[3:0] == 4'h8));
    assert_proc_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PROC_RD) |-> (req_addr[3:0] == 4'h0));
endmodule

// File: rtl/radix_root_locator.sv
module radix_root_locator
    import rrf_pkg::*;
#(
    parameter int LPID_W = 12,
    parameter int PID_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [63:0]       ptcr,
    input  logic [LPID_W-1:0] lpid,
    input  logic [PID_W-1:0]  pid,
    output logic              mem_req_valid,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic              done,
    output logic              fault,
    output logic [63:0]       root_base,
    output logic [4:0]        root_idx_bits,
    output logic [5:0]        tree_bits
);
    logic [DW-1:0]     ptcr_q, pate_q, prte_q, part_addr, proc_addr;
    logic [LPID_W-1:0] lpid_q;
    logic [PID_W-1:0]  pid_q;
    logic [CODE_W-1:0] part_code, proc_code;
    logic              part_oor, proc_oor, root_bad;

    rrf_table_ptr #(.IDX_W(LPID_W), .ALIGN(1'b0), .ENTRY_OFF(64'd8)) u_part (
        .dword(ptcr_q), .idx(lpid_q), .entry_addr(part_addr),
        .size_code(part_code), .out_of_range(part_oor)
    );

    rrf_table_ptr #(.IDX_W(PID_W), .ALIGN(1'b1), .ENTRY_OFF(64'd0)) u_proc (
        .dword(pate_q), .idx(pid_q), .entry_addr(proc_addr),
        .size_code(proc_code), .out_of_range(proc_oor)
    );

    rrf_root_decode u_root (
        .dword(prte_q), .root_base(root_base), .idx_bits(root_idx_bits),
        .tree_bits(tree_bits), .size_bad(root_bad)
    );

    rrf_fsm #(.LPID_W(LPID_W), .PID_W(PID_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ptcr_in(ptcr), .lpid_in(lpid), .pid_in(pid),
        .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
        .part_oor(part_oor), .proc_code(proc_code), .proc_oor(proc_oor),
        .root_bad(root_bad), .part_addr(part_addr), .proc_addr(proc_addr),
        .ptcr_q(ptcr_q), .lpid_q(lpid_q), .pid_q(pid_q),
        .pate_q(pate_q), .prte_q(prte_q),
        .req_valid(mem_req_valid), .req_addr(mem_req_addr),
        .done(done), .fault(fault)
    );

    // the partition size code only bounds the index
    logic unused_code;
    assign unused_code = ^part_code;

    assert_root_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (root_idx_bits >= 5'd5));
    assert_tree_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tree_bits >= 6'd31));
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !mem_req_valid && !done && !fault);
endmodule

// File: tb/tb_radix_root_locator.sv
module tb_radix_root_locator;
    localparam int LW = 12;
    localparam int PW = 20;

    function automatic logic [63:0] put(int a, int b, logic [63:0] v);
        logic [63:0] m;
        m = (64'd1 << (b - a + 1)) - 64'd1;
        return (v & m) << (63 - b);
    endfunction

    function automatic logic [63:0] fld(logic [63:0] v, int a, int b);
        return (v >> (63 - b)) & ((64'd1 << (b - a + 1)) - 64'd1);
    endfunction

    function automatic logic [63:0] mk_ptr(logic [63:0] base, logic [63:0] code);
        return put(4, 51, base) | put(59, 63, code);
    endfunction

    function automatic logic [63:0] mk_root(logic [63:0] hi, logic [63:0] rb,
                                            logic [63:0] lo, logic [63:0] code);
        return put(1, 2, hi) | put(4, 55, rb) | put(56, 58, lo) | put(59, 63, code);
    endfunction

    typedef struct packed {
        logic [63:0]   ptcr;
        logic [LW-1:0] lp;
        logic [PW-1:0] pd;
        logic [63:0]   pate;
        logic [63:0]   prte;
        logic [3:0]    lat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{mk_ptr(64'h12345, 0), 12'd3,    20'd10,    mk_ptr(64'hABCDE, 4),  mk_root(1, 64'h123456789, 5, 9),      4'd1},
        '{mk_ptr(64'h00200, 0), 12'd255,  20'd255,   mk_ptr(64'h7777, 0),   mk_root(0, 64'hFEDCBA9876543, 0, 5),  4'd3},
        '{mk_ptr(64'h00200, 0), 12'd256,  20'd1,     mk_ptr(64'h7777, 0),   mk_root(0, 64'h1, 0, 5),              4'd1},
        '{mk_ptr(64'h00400, 2), 12'd700,  20'd1,     mk_ptr(64'h5000, 25),  mk_root(0, 64'h1, 0, 6),              4'd2},
        '{mk_ptr(64'h00800, 3), 12'd2047, 20'hFFFFF, mk_ptr(64'hFFFFFFFFFFFF, 24), mk_root(3, 64'hFFFFFFFFFFFFF, 7, 31), 4'd5},
        '{mk_ptr(64'h01000, 0), 12'd0,    20'd256,   mk_ptr(64'h9000, 0),   mk_root(1, 64'h42, 1, 8),             4'd1},
        '{mk_ptr(64'h01000, 0), 12'd1,    20'd2,     mk_ptr(64'h9000, 1),   mk_root(2, 64'h42, 3, 4),             4'd2},
        '{mk_ptr(64'h02000, 1), 12'd300,  20'd4000,  mk_ptr(64'h3C0F0, 6),  mk_root(2, 64'h55AA, 1, 13),          4'd1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [63:0]   ptcr = '0;
    logic [LW-1:0] lpid = '0;
    logic [PW-1:0] pid = '0;
    logic          mem_req_valid;
    logic [63:0]   mem_req_addr;
    logic          mem_rsp_valid;
    logic [63:0]   mem_rsp_data = '0;
    logic          done, fault;
    logic [63:0]   root_base;
    logic [4:0]    root_idx_bits;
    logic [5:0]    tree_bits;

    logic resp_pulse = 1'b0;
    logic stray_pulse = 1'b0;
    assign mem_rsp_valid = resp_pulse | stray_pulse;

    int tests = 0;
    int fails = 0;
    int lat = 1;
    int rd_cnt = 0;
    logic [63:0] rd_addr [2];
    logic [63:0] m_a1, m_a2, m_d1, m_d2;

    always #10 clk = ~clk;

    radix_root_locator #(.LPID_W(LW), .PID_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ptcr(ptcr), .lpid(lpid), .pid(pid),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .root_base(root_base),
        .root_idx_bits(root_idx_bits), .tree_bits(tree_bits)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                if (rd_cnt < 2) rd_addr[rd_cnt] = mem_req_addr;
                rd_cnt++;
                if (mem_req_addr == m_a1)      mem_rsp_data = m_d1;
                else if (mem_req_addr == m_a2) mem_rsp_data = m_d2;
                else                           mem_rsp_data = 64'h0;
                repeat (lat) @(negedge clk);
                resp_pulse = 1'b1;
                @(negedge clk);
                resp_pulse = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic run_vec(vec_t v, bit poke);
        bit          e_f;
        int          e_n;
        logic [63:0] pb, tb, off, a1, a2, rb;
        logic [63:0] pc, tc, rs, tw;
        int          seen_d, seen_f, cyc;
        e_f = 0; e_n = 0; a1 = '0; a2 = '0; rb = '0; rs = '0; tw = '0;
        pb  = fld(v.ptcr, 4, 51) << 12;
        pc  = fld(v.ptcr, 59, 63);
        off = 64'(v.lp) << 4;
        if (off >= (64'd1 << (pc + 12))) e_f = 1;            // R3
        else begin
            e_n = 1;
            a1 = pb + off + 64'd8;                             // R2
            tc = fld(v.pate, 59, 63);
            tb = ((fld(v.pate, 4, 51) >> tc) << tc) << 12;     // R4
            off = 64'(v.pd) << 4;
            if (tc > 24) e_f = 1;                              // R5
            else if (off >= (64'd1 << (tc + 12))) e_f = 1;     // R6
            else begin
                e_n = 2;
                a2 = tb + off;
                rs = fld(v.prte, 59, 63);
                if (rs < 5) e_f = 1;                           // R8
                rb = fld(v.prte, 4, 55) << 8;                  // R7
                tw = fld(v.prte, 1, 2) * 8 + fld(v.prte, 56, 58) + 31;
            end
        end
        m_a1 = a1; m_a2 = a2; m_d1 = v.pate; m_d2 = v.prte;
        lat = int'(v.lat); rd_cnt = 0; rd_addr[0] = '0; rd_addr[1] = '0;
        @(negedge clk);
        start = 1'b1; ptcr = v.ptcr; lpid = v.lp; pid = v.pd;
        @(negedge clk);
        start = 1'b0;
        seen_d = 0; seen_f = 0; cyc = 0;
        while (!(done || fault) && cyc < 300) begin
            if (poke && cyc == 1) begin                        // R10 busy start
                start = 1'b1; ptcr = 64'hFFFF_FFFF_FFFF_FFFF; lpid = '1; pid = '1;
            end else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        seen_d = int'(done); seen_f = int'(fault);
        chk("R10 outcome fault", 64'(seen_f), 64'(e_f));
        chk("R10 outcome done", 64'(seen_d), 64'(!e_f));
        chk("R9 read count", 64'(rd_cnt), 64'(e_n));
        if (e_n >= 1) chk("R2 partition address", rd_addr[0], a1);
        if (e_n >= 2) chk("R4 process address", rd_addr[1], a2);
        if (!e_f) begin
            chk("R7 root base", root_base, rb);
            chk("R7 root index width", 64'(root_idx_bits), rs);
            chk("R7 tree width", 64'(tree_bits), tw);
        end
        @(negedge clk);
        chk("R10 single-cycle pulse", 64'({done, fault}), 64'd0);
        repeat (2) @(negedge clk);
        chk("R9 no extra read", 64'(rd_cnt), 64'(e_n));
    endtask

    initial begin
        m_a1 = 64'h1; m_a2 = 64'h1; m_d1 = '0; m_d2 = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset done", 64'(done), 64'd0);
        chk("R1 reset fault", 64'(fault), 64'd0);
        chk("R1 reset request", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", 64'({done, fault, mem_req_valid}), 64'd0);

        // stray response while idle
        stray_pulse = 1'b1;
        @(negedge clk);
        stray_pulse = 1'b0;
        begin
            int act = 0;
            for (int k = 0; k < 4; k++) begin
                if (done || fault || mem_req_valid) act = 1;
                @(negedge clk);
            end
            chk("R9 stray response ignored", 64'(act), 64'd0);
        end

        for (int i = 0; i < NV; i++) run_vec(VECS[i], (i % 2) == 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule